// File: doc/BRIEF.md
# Accumulator Machine Sequencer

This block is the control core of a small accumulator processor that uses 24-bit data words and 20-bit addresses. On each step it reads the word pointed to by its instruction address register and splits it into a four-bit primary code and an argument. It then carries out the instruction with a short multi-cycle sequence through one single-port synchronous memory port. The core holds the accumulator, a return-address register, a stack-base register and a frame register. A child ALU produces the arithmetic and logic results.

Execution stops in one of three ways: an explicit stop instruction, a word that decodes to nothing, or a step that would move the instruction address past its last value. The core then parks, holds its memory strobe low and reports a two-bit cause code until the next reset. A system integrator attaches a memory whose read data appears one clock after the address and then releases reset. The core starts fetching at address zero.

Top module: `accm_core`

## Requirements
- R1: A synchronous reset clears every register to zero. In the first cycle after reset, `mem_addr` is 0, `mem_we` is 0, `halted` is 0 and `halt_cause` is 0 (0 running, 1 stop instruction, 2 undecodable, 3 address overflow).
- R2: Bits 23:20 of an instruction select a primary code 0x0 to 0xE with a 20-bit argument in bits 19:0. Code 0x0 loads the argument into the accumulator with bits 23:20 cleared.
- R3: Primary codes 0x1 (load), 0x3 (add modulo 2^24), 0x4 (and), 0x5 (or), 0x6 (xor) and 0x7 (equal: all ones if equal, else zero) combine the accumulator with the memory word at the argument address.
- R4: When bits 23:20 are 0xF, bits 19:16 select a secondary code and bits 15:0 hold an immediate. 0xF1 inverts the accumulator, 0xF2 rotates it right by one bit, and 0xFA adds the sign-extended immediate.
- R5: Primary code 0x2 writes the accumulator to the argument address with a single write strobe.
- R6: Code 0x8 always jumps to the argument. Code 0x9 jumps only when accumulator bit 23 is set; otherwise execution continues at the next address.
- R7: Code 0xC stores the current address plus one in the return register and jumps to the argument. Code 0xF3 loads the instruction address from the return register.
- R8: Codes 0xA (indirect load) and 0xB (indirect store) read a pointer word at the argument address and use only its low 20 bits as the data address.
- R9: Codes 0xD and 0xE load from, or store to, the address given by the stack-base register plus the argument, modulo 2^20.
- R10: Codes 0xF4/0xF5 read and write the stack-base register, 0xF6/0xF7 the frame register, and 0xF8/0xF9 the return register. A write takes accumulator bits 19:0, and a read zero-fills accumulator bits 23:20.
- R11: Code 0xF0 stops execution with cause 1. Once stopped, the core makes no memory write and keeps `halted` and `halt_cause` unchanged until reset.
- R12: Codes 0xFB to 0xFF are undecodable. They stop execution with cause 2 and have no effect on memory or registers.
- R13: At address 0xFFFFF, an instruction that does not load the instruction address completes its effect and then stops with cause 3. A jump taken from that address continues normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 20 | Memory word address |
| mem_wdata | output | 24 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 24 | Memory read data, valid one cycle after its address |
| halted | output | 1 | Execution has stopped |
| halt_cause | output | 2 | Stop reason code |

## Verification
The assertions assume a memory that returns data exactly one cycle after the address and that reset is held for at least one clock edge before the first checked cycle. The bench models the memory as a registered, read-first array that aliases the address to its low eight bits. It loads programs only while reset is asserted, so the core never sees a write from the loader. Programs avoid placing code or data at any low byte that clashes with the aliased location used for the top address 0xFFFFF.

// File: rtl/accm_pkg.sv
package accm_pkg;

   typedef enum logic [2:0] {
      ST_FETCH  = 3'd0,
      ST_DECODE = 3'd1,
      ST_READ   = 3'd2,
      ST_PTR    = 3'd3,
      ST_HALT   = 3'd4
   } state_t;

   typedef enum logic [1:0] {
      CAUSE_RUN  = 2'd0,
      CAUSE_STOP = 2'd1,
      CAUSE_BAD  = 2'd2,
      CAUSE_OVF  = 2'd3
   } cause_t;

   typedef enum logic [4:0] {
      I_LDC, I_LDV, I_STV, I_ADD, I_AND, I_OR, I_XOR, I_EQL,
      I_JMP, I_JMN, I_LDIV, I_STIV, I_CALL, I_LDVR, I_STVR,
      I_STOP, I_INV, I_ROR, I_RET, I_GSP, I_PSP, I_GFP, I_PFP,
      I_GRA, I_PRA, I_ADDI, I_BAD
   } instr_t;

   typedef enum logic [3:0] {
      ALU_PASS, ALU_ADD, ALU_AND, ALU_OR, ALU_XOR,
      ALU_EQL, ALU_INV, ALU_ROR, ALU_ADDI
   } alu_op_t;

endpackage

// File: rtl/accm_decode.sv
module accm_decode
   import accm_pkg::*;
#(
   parameter int WORD_W = 24,
   parameter int ADDR_W = 20,
   parameter int OPC_W  = 4,
   localparam int IMM_W = WORD_W - 2 * OPC_W
) (
   input  logic [WORD_W-1:0] word,
   output instr_t            instr,
   output logic [ADDR_W-1:0] arg,
   output logic [IMM_W-1:0]  imm
);

   if (OPC_W != 4) begin : g_bad_opc
      $error("accm_decode: opcode field must be 4 bits");
   end
   if (WORD_W != ADDR_W + OPC_W) begin : g_bad_split
      $error("accm_decode: word must equal opcode plus address");
   end

   logic [OPC_W-1:0] pri;
   logic [OPC_W-1:0] sec;

   assign pri = word[WORD_W-1 -: OPC_W];
   assign sec = word[WORD_W-OPC_W-1 -: OPC_W];
   assign arg = word[ADDR_W-1:0];
   assign imm = word[IMM_W-1:0];

   always_comb begin
      case (pri)
         4'h0: instr = I_LDC;
         4'h1: instr = I_LDV;
         4'h2: instr = I_STV;
         4'h3: instr = I_ADD;
         4'h4: instr = I_AND;
         4'h5: instr = I_OR;
         4'h6: instr = I_XOR;
         4'h7: instr = I_EQL;
         4'h8: instr = I_JMP;
         4'h9: instr = I_JMN;
         4'hA: instr = I_LDIV;
         4'hB: instr = I_STIV;
         4'hC: instr = I_CALL;
         4'hD: instr = I_LDVR;
         4'hE: instr = I_STVR;
         default: begin
            case (sec)
               4'h0:    instr = I_STOP;
               4'h1:    instr = I_INV;
               4'h2:    instr = I_ROR;
               4'h3:    instr = I_RET;
               4'h4:    instr = I_GSP;
               4'h5:    instr = I_PSP;
               4'h6:    instr = I_GFP;
               4'h7:    instr = I_PFP;
               4'h8:    instr = I_GRA;
               4'h9:    instr = I_PRA;
               4'hA:    instr = I_ADDI;
               default: instr = I_BAD;
            endcase
         end
      endcase
   end

endmodule

// File: rtl/accm_alu.sv
module accm_alu
   import accm_pkg::*;
#(
   parameter int WORD_W     = 24,
   parameter int IMM_W      = 16,
   parameter bit SIGNED_IMM = 1'b1
) (
   input  alu_op_t           op,
   input  logic [WORD_W-1:0] acc,
   input  logic [WORD_W-1:0] opnd,
   input  logic [IMM_W-1:0]  imm,
   output logic [WORD_W-1:0] res
);

   if (IMM_W >= WORD_W) begin : g_bad_imm
      $error("accm_alu: immediate must be narrower than the word");
   end

   logic [WORD_W-1:0] imm_ext;

   if (SIGNED_IMM) begin : g_sext
      assign imm_ext = {{(WORD_W-IMM_W){imm[IMM_W-1]}}, imm};
   end else begin : g_zext
      assign imm_ext = {{(WORD_W-IMM_W){1'b0}}, imm};
   end

   always_comb begin
      case (op)
         ALU_ADD:  res = acc + opnd;
         ALU_AND:  res = acc & opnd;
         ALU_OR:   res = acc | opnd;
         ALU_XOR:  res = acc ^ opnd;
         ALU_EQL:  res = (acc == opnd) ? '1 : '0;
         ALU_INV:  res = ~acc;
         ALU_ROR:  res = {acc[0], acc[WORD_W-1:1]};
         ALU_ADDI: res = acc + imm_ext;
         default:  res = opnd;
      endcase
   end

endmodule

// File: rtl/accm_addrgen.sv
module accm_addrgen #(
   parameter int ADDR_W = 20
) (
   input  logic [ADDR_W-1:0] iar,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] offs,
   output logic [ADDR_W-1:0] iar_inc,
   output logic              iar_last,
   output logic [ADDR_W-1:0] rel_addr
);

   localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

   assign iar_inc  = iar + ADDR_W'(1);
   assign iar_last = (iar == LAST_ADDR);
   assign rel_addr = base + offs;

endmodule

// File: rtl/accm_core.sv
module accm_core
   import accm_pkg::*;
#(
   parameter int WORD_W     = 24,
   parameter int ADDR_W     = 20,
   parameter int OPC_W      = 4,
   parameter bit SIGNED_IMM = 1'b1,
   localparam int IMM_W     = WORD_W - 2 * OPC_W,
   localparam int PAD_W     = WORD_W - ADDR_W
) (
   input  logic              clk,
   input  logic              rst,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   output logic              mem_we,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              halted,
   output logic [1:0]        halt_cause
);

   if (PAD_W != OPC_W) begin : g_bad_widths
      $error("accm_core: word width must be address width plus opcode width");
   end

   state_t            state, nxt_state;
   cause_t            cause, nxt_cause;
   logic [ADDR_W-1:0] iar, nxt_iar;
   logic [WORD_W-1:0] acc, nxt_acc;
   logic [ADDR_W-1:0] ra, nxt_ra;
   logic [ADDR_W-1:0] sp, nxt_sp;
   logic [ADDR_W-1:0] fp, nxt_fp;
   logic [WORD_W-1:0] ir, nxt_ir;

   logic [WORD_W-1:0] dec_word;
   instr_t            instr;
   logic [ADDR_W-1:0] arg;
   logic [IMM_W-1:0]  imm;
   alu_op_t           alu_op;
   logic [WORD_W-1:0] alu_opnd;
   logic [WORD_W-1:0] alu_res;
   logic [ADDR_W-1:0] iar_inc;
   logic              iar_last;
   logic [ADDR_W-1:0] rel_addr;
   logic              advance;

   function automatic logic [WORD_W-1:0] widen(input logic [ADDR_W-1:0] v);
      return {{PAD_W{1'b0}}, v};
   endfunction

   assign dec_word = (state == ST_DECODE) ? mem_rdata : ir;

   accm_decode #(
      .WORD_W (WORD_W),
      .ADDR_W (ADDR_W),
      .OPC_W  (OPC_W)
   ) u_decode (
      .word  (dec_word),
      .instr (instr),
      .arg   (arg),
      .imm   (imm)
   );

   accm_addrgen #(
      .ADDR_W (ADDR_W)
   ) u_addrgen (
      .iar      (iar),
      .base     (sp),
      .offs     (arg),
      .iar_inc  (iar_inc),
      .iar_last (iar_last),
      .rel_addr (rel_addr)
   );

   always_comb begin
      case (instr)
         I_ADD:   alu_op = ALU_ADD;
         I_AND:   alu_op = ALU_AND;
         I_OR:    alu_op = ALU_OR;
         I_XOR:   alu_op = ALU_XOR;
         I_EQL:   alu_op = ALU_EQL;
         I_INV:   alu_op = ALU_INV;
         I_ROR:   alu_op = ALU_ROR;
         I_ADDI:  alu_op = ALU_ADDI;
         default: alu_op = ALU_PASS;
      endcase
   end

   always_comb begin
      if (state == ST_DECODE) begin
         case (instr)
            I_LDC:   alu_opnd = widen(arg);
            I_GSP:   alu_opnd = widen(sp);
            I_GFP:   alu_opnd = widen(fp);
            I_GRA:   alu_opnd = widen(ra);
            default: alu_opnd = mem_rdata;
         endcase
      end else begin
         alu_opnd = mem_rdata;
      end
   end

   accm_alu #(
      .WORD_W     (WORD_W),
      .IMM_W      (IMM_W),
      .SIGNED_IMM (SIGNED_IMM)
   ) u_alu (
      .op   (alu_op),
      .acc  (acc),
      .opnd (alu_opnd),
      .imm  (imm),
      .res  (alu_res)
   );

   always_comb begin
      nxt_state = state;
      nxt_cause = cause;
      nxt_iar   = iar;
      nxt_acc   = acc;
      nxt_ra    = ra;
      nxt_sp    = sp;
      nxt_fp    = fp;
      nxt_ir    = ir;
      mem_addr  = iar;
      mem_wdata = acc;
      mem_we    = 1'b0;
      advance   = 1'b0;

      case (state)
         ST_FETCH: begin
            nxt_state = ST_DECODE;
         end
         ST_DECODE: begin
            nxt_ir = mem_rdata;
            case (instr)
               I_LDC, I_INV, I_ROR, I_ADDI, I_GSP, I_GFP, I_GRA: begin
                  nxt_acc = alu_res;
                  advance = 1'b1;
               end
               I_LDV, I_ADD, I_AND, I_OR, I_XOR, I_EQL: begin
                  mem_addr  = arg;
                  nxt_state = ST_READ;
               end
               I_STV: begin
                  mem_addr = arg;
                  mem_we   = 1'b1;
                  advance  = 1'b1;
               end
               I_JMP: begin
                  nxt_iar   = arg;
                  nxt_state = ST_FETCH;
               end
               I_JMN: begin
                  if (acc[WORD_W-1]) begin
                     nxt_iar   = arg;
                     nxt_state = ST_FETCH;
                  end else begin
                     advance = 1'b1;
                  end
               end
               I_LDIV, I_STIV: begin
                  mem_addr  = arg;
                  nxt_state = ST_PTR;
               end
               I_CALL: begin
                  nxt_ra    = iar_inc;
                  nxt_iar   = arg;
                  nxt_state = ST_FETCH;
               end
               I_LDVR: begin
                  mem_addr  = rel_addr;
                  nxt_state = ST_READ;
               end
               I_STVR: begin
                  mem_addr = rel_addr;
                  mem_we   = 1'b1;
                  advance  = 1'b1;
               end
               I_RET: begin
                  nxt_iar   = ra;
                  nxt_state = ST_FETCH;
               end
               I_PSP: begin
                  nxt_sp  = acc[ADDR_W-1:0];
                  advance = 1'b1;
               end
               I_PFP: begin
                  nxt_fp  = acc[ADDR_W-1:0];
                  advance = 1'b1;
               end
               I_PRA: begin
                  nxt_ra  = acc[ADDR_W-1:0];
                  advance = 1'b1;
               end
               I_STOP: begin
                  nxt_state = ST_HALT;
                  nxt_cause = CAUSE_STOP;
               end
               default: begin
                  nxt_state = ST_HALT;
                  nxt_cause = CAUSE_BAD;
               end
            endcase
         end
         ST_READ: begin
            nxt_acc = alu_res;
            advance = 1'b1;
         end
         ST_PTR: begin
            mem_addr = mem_rdata[ADDR_W-1:0];
            if (instr == I_STIV) begin
               mem_we  = 1'b1;
               advance = 1'b1;
            end else begin
               nxt_state = ST_READ;
            end
         end
         default: begin
            nxt_state = ST_HALT;
         end
      endcase

      if (advance) begin
         if (iar_last) begin
            nxt_state = ST_HALT;
            nxt_cause = CAUSE_OVF;
         end else begin
            nxt_iar   = iar_inc;
            nxt_state = ST_FETCH;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_FETCH;
         cause <= CAUSE_RUN;
         iar   <= '0;
         acc   <= '0;
         ra    <= '0;
         sp    <= '0;
         fp    <= '0;
         ir    <= '0;
      end else begin
         state <= nxt_state;
         cause <= nxt_cause;
         iar   <= nxt_iar;
         acc   <= nxt_acc;
         ra    <= nxt_ra;
         sp    <= nxt_sp;
         fp    <= nxt_fp;
         ir    <= nxt_ir;
      end
   end

   assign halted     = (state == ST_HALT);
   assign halt_cause = cause;

endmodule

// File: rtl/accm_core_chk.sv
module accm_core_chk #(
   parameter int ADDR_W = 20
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_we,
   input logic              halted,
   input logic [1:0]        halt_cause
);

   AST_RESET_FETCH: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (mem_addr == '0 && !mem_we && !halted && halt_cause == 2'd0)); // R1

   AST_RUN_NO_CAUSE: assert property (@(posedge clk) disable iff (rst)
      !halted |-> (halt_cause == 2'd0)); // R1

   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
      halted |=> (halted && $stable(halt_cause))); // R11

   AST_NO_WRITE_HALTED: assert property (@(posedge clk) disable iff (rst)
      halted |-> !mem_we); // R11

   AST_HALT_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
      $rose(halted) |-> (halt_cause != 2'd0)); // R12

endmodule

bind accm_core accm_core_chk u_chk (
   .clk        (clk),
   .rst        (rst),
   .mem_addr   (mem_addr),
   .mem_we     (mem_we),
   .halted     (halted),
   .halt_cause (halt_cause)
);

// File: tb/accm_core_bench.sv
`timescale 1ns/1ps
module accm_core_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [19:0] mem_addr;
   logic [23:0] mem_wdata;
   logic        mem_we;
   logic [23:0] mem_rdata;
   logic        halted;
   logic [1:0]  halt_cause;

   logic [23:0] mem [256];
   logic        ld_en = 1'b0;
   logic [7:0]  ld_addr = '0;
   logic [23:0] ld_data = '0;

   int checks = 0;
   int failures = 0;

   // {instruction, starting accumulator, operand at 0x81, expected result}
   localparam int NV = 14;
   localparam logic [95:0] VECS [NV] = '{
      {24'h0ABCDE, 24'hFFFFFF, 24'h000000, 24'h0ABCDE},  // R2 load constant
      {24'h100081, 24'h000000, 24'hABCDEF, 24'hABCDEF},  // R3 load
      {24'h300081, 24'h000005, 24'h000007, 24'h00000C},  // R3 add
      {24'h300081, 24'hFFFFFF, 24'h000002, 24'h000001},  // R3 add wrap
      {24'h400081, 24'hF0F0F0, 24'h3C3C3C, 24'h303030},  // R3 and
      {24'h500081, 24'hF0F0F0, 24'h0F0F00, 24'hFFFFF0},  // R3 or
      {24'h600081, 24'hFF00FF, 24'h0F0F0F, 24'hF00FF0},  // R3 xor
      {24'h700081, 24'h123456, 24'h123456, 24'hFFFFFF},  // R3 equal
      {24'h700081, 24'h123456, 24'h123457, 24'h000000},  // R3 not equal
      {24'hF10000, 24'h0F0F0F, 24'h000000, 24'hF0F0F0},  // R4 invert
      {24'hF20000, 24'h000003, 24'h000000, 24'h800001},  // R4 rotate
      {24'hFAFFFF, 24'h000010, 24'h000000, 24'h00000F},  // R4 add -1
      {24'hFA0005, 24'h000010, 24'h000000, 24'h000015},  // R4 add +5
      {24'hFA8000, 24'h000000, 24'h000000, 24'hFF8000}   // R4 add min
   };
   localparam string VTAG [NV] = '{
      "R2", "R3", "R3", "R3", "R3", "R3", "R3",
      "R3", "R3", "R4", "R4", "R4", "R4", "R4"
   };

   accm_core u_accm_core (
      .clk        (clk),
      .rst        (rst),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_we     (mem_we),
      .mem_rdata  (mem_rdata),
      .halted     (halted),
      .halt_cause (halt_cause)
   );

   always #2 clk = ~clk;

   always @(posedge clk) begin
      if (ld_en) mem[ld_addr] <= ld_data;
      else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[7:0]];
   end

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      report();
      $finish;
   end

   task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%06h expected=%06h", req, act, exp);
      end
   endtask

   // caller is at a falling edge
   task automatic put(input logic [7:0] a, input logic [23:0] d);
      ld_en = 1'b1;
      ld_addr = a;
      ld_data = d;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic begin_prog();
      @(negedge clk);
      rst = 1'b1;
      for (int i = 0; i < 256; i++) put(8'(i), 24'h0);
   endtask

   task automatic run_prog();
      rst = 1'b0;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (halted) break;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);

      // table of single-instruction programs
      for (int v = 0; v < NV; v++) begin
         begin_prog();
         put(8'h00, 24'h100080);
         put(8'h01, VECS[v][95:72]);
         put(8'h02, 24'h200082);
         put(8'h03, 24'hF00000);
         put(8'h80, VECS[v][71:48]);
         put(8'h81, VECS[v][47:24]);
         run_prog();
         chk(VTAG[v], mem[8'h82], VECS[v][23:0]);
         chk("R11", {22'h0, halt_cause}, 24'd1);
      end

      // R1: state right after reset release
      begin_prog();
      put(8'h00, 24'h800000);
      rst = 1'b0;
      chk("R1", {4'h0, mem_addr}, 24'h0);
      chk("R1", {22'h0, halt_cause, halted, mem_we}, 24'h0);

      // R6: conditional jump taken
      begin_prog();
      put(8'h00, 24'h100080);
      put(8'h01, 24'h900010);
      put(8'h02, 24'hF00000);
      put(8'h10, 24'h000001);
      put(8'h11, 24'h200082);
      put(8'h12, 24'hF00000);
      put(8'h80, 24'h800000);
      run_prog();
      chk("R6", mem[8'h82], 24'h000001);

      // R6 not taken, R5 store of accumulator
      begin_prog();
      put(8'h00, 24'h100080);
      put(8'h01, 24'h900010);
      put(8'h02, 24'h200082);
      put(8'h03, 24'hF00000);
      put(8'h10, 24'h000001);
      put(8'h80, 24'h7FFFFF);
      run_prog();
      chk("R6", {22'h0, halt_cause}, 24'd1);
      chk("R5", mem[8'h82], 24'h7FFFFF);

      // R7: call and return
      begin_prog();
      put(8'h00, 24'h000007);
      put(8'h01, 24'hC00020);
      put(8'h02, 24'h200083);
      put(8'h03, 24'hF00000);
      put(8'h20, 24'hF80000);
      put(8'h21, 24'h200082);
      put(8'h22, 24'hF30000);
      run_prog();
      chk("R7", mem[8'h82], 24'h000002);
      chk("R7", mem[8'h83], 24'h000002);

      // R8: indirect load and store
      begin_prog();
      put(8'h00, 24'hA00081);
      put(8'h01, 24'hB00084);
      put(8'h02, 24'hF00000);
      put(8'h81, 24'hF00090);
      put(8'h84, 24'h5000A0);
      put(8'h90, 24'h777777);
      run_prog();
      chk("R8", mem[8'hA0], 24'h777777);

      // R9 and R10: register moves and stack-relative access
      begin_prog();
      put(8'h00, 24'h100080);
      put(8'h01, 24'hF50000);
      put(8'h02, 24'hF40000);
      put(8'h03, 24'h200082);
      put(8'h04, 24'hD00005);
      put(8'h05, 24'h200083);
      put(8'h06, 24'hE00006);
      put(8'h07, 24'h100080);
      put(8'h08, 24'hF70000);
      put(8'h09, 24'hF60000);
      put(8'h0A, 24'h200084);
      put(8'h0B, 24'h100080);
      put(8'h0C, 24'hF90000);
      put(8'h0D, 24'hF80000);
      put(8'h0E, 24'h200085);
      put(8'h0F, 24'hF00000);
      put(8'h45, 24'h13579B);
      put(8'h80, 24'hF00040);
      run_prog();
      chk("R10", mem[8'h82], 24'h000040);
      chk("R9", mem[8'h83], 24'h13579B);
      chk("R9", mem[8'h46], 24'h13579B);
      chk("R10", mem[8'h84], 24'h000040);
      chk("R10", mem[8'h85], 24'h000040);

      // R12: undecodable word stops before the following store
      begin_prog();
      put(8'h00, 24'h000005);
      put(8'h01, 24'hFB1234);
      put(8'h02, 24'h200082);
      run_prog();
      chk("R12", {22'h0, halt_cause}, 24'd2);
      repeat (30) @(negedge clk);
      chk("R12", mem[8'h82], 24'h000000);
      chk("R11", {23'h0, halted}, 24'd1);

      begin_prog();
      put(8'h00, 24'hFF0000);
      run_prog();
      chk("R12", {22'h0, halt_cause}, 24'd2);

      // R13: store at the top address completes, then overflow stop
      begin_prog();
      put(8'h00, 24'h000ABC);
      put(8'h01, 24'h8FFFFF);
      put(8'hFF, 24'h200082);
      run_prog();
      chk("R13", {22'h0, halt_cause}, 24'd3);
      chk("R13", mem[8'h82], 24'h000ABC);

      // R1: reset after a stop clears the halt report
      rst = 1'b1;
      @(negedge clk);
      chk("R1", {22'h0, halt_cause, halted, mem_we}, 24'h0);

      // R13: jump from the top address keeps running
      begin_prog();
      put(8'h00, 24'h8FFFFF);
      put(8'hFF, 24'h800010);
      put(8'h10, 24'hF00000);
      run_prog();
      chk("R13", {22'h0, halt_cause}, 24'd1);

      report();
      $finish;
   end

endmodule